// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a compact 32-bit processor that completes every instruction in one clock. Each cycle the word at the program counter is fetched from a small internal instruction array. A purely combinational decode of the 6-bit opcode then sets the operand selects, the register and memory write enables, and the next-PC choice. A second decode turns a 2-bit operation class, together with the funct field for register-to-register instructions, into a 3-bit ALU control. The supported set is five register-to-register operations (add, sub, and, or, slt), word load, word store, branch-if-equal, add-immediate and an absolute jump.

Instruction fields sit at fixed bit positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], the 16-bit immediate [15:0] and the 26-bit jump target [25:0]. Both memories are word arrays indexed by byte address bits above bit 1. A load port fills them while the core is idle. A run enable gates all state updates, and combinational observation ports expose one register and one data word at a time. The core is stepped with the run enable and inspected through those ports when a program has finished.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low the PC reads 0; while run_en is low the PC holds its value; on each enabled clock without a taken branch or jump the PC advances by 4.
- R2: The register file holds 32 words of 32 bits, with two operand read ports addressed by rs and rt and one write port; register 0 always reads as zero, even after an instruction targets it.
- R3: Opcode 000000 writes rs op rt to rd, where funct 100000 selects add, 100010 sub, 100100 and, 100101 or, and 101010 signed set-less-than (result 1 or 0).
- R4: Opcode 100011 loads the data word at rs plus the sign-extended immediate into rt; an address that is not a multiple of 4 or lies past the data array loads zero.
- R5: Opcode 101011 stores rt at the address formed as for a load, on the rising clock edge, and writes no register; a misaligned or out-of-range store changes nothing.
- R6: Opcode 000100 compares rs with rt by subtraction; when they are equal the next PC is PC+4 plus the sign-extended immediate shifted left by 2, otherwise PC+4. Negative offsets branch backwards.
- R7: Opcode 001000 writes rs plus the sign-extended 16-bit immediate to rt.
- R8: Opcode 000010 sets the next PC to the upper 4 bits of PC+4, then the 26-bit target, then two zero bits, and writes neither registers nor memory.
- R9: Any other opcode only advances the PC by 4.
- R10: With ld_we high, ld_data is written on the clock edge into the word at ld_addr, of the data array when ld_dmem is 1 and of the instruction array when it is 0; dbg_reg_data and dbg_mem_data show the register and data word selected by their address inputs without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Executes one instruction per clock while high |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 1 data array, 0 instruction array |
| ld_addr | input | MAW | Load-port word index |
| ld_data | input | 32 | Load-port write data |
| dbg_reg_addr | input | 5 | Register selected for observation |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_mem_addr | input | MAW | Data word selected for observation |
| dbg_mem_data | output | 32 | Contents of the selected data word |
| pc | output | 32 | Current program counter (byte address) |

## Verification
One program covers every opcode. It uses a negative immediate for sign extension and set-less-than with operands of opposite sign, where an unsigned compare would give the opposite answer. An instruction that targets register 0 tests that register 0 stays zero. A not-taken branch sits ahead of a taken one, and a later branch with a negative offset closes a two-pass loop. A decode that swapped the branch sense, dropped the offset shift or ignored the sign would leave a skipped instruction's value in a register or a wrong loop counter. An unlisted opcode whose rt and immediate fields would overwrite a live register catches a decode that falls through to a write. A misaligned store and an out-of-range load catch address checks that truncate the address.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int unsigned XLEN = 32;
  localparam int unsigned RAW  = 5;

  localparam logic [5:0] OPC_REG  = 6'b000000;
  localparam logic [5:0] OPC_LOAD = 6'b100011;
  localparam logic [5:0] OPC_STOR = 6'b101011;
  localparam logic [5:0] OPC_BREQ = 6'b000100;
  localparam logic [5:0] OPC_ADDI = 6'b001000;
  localparam logic [5:0] OPC_JUMP = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_ctl_e;

  typedef enum logic [1:0] {
    OPK_ADD   = 2'b00,
    OPK_SUB   = 2'b01,
    OPK_FUNCT = 2'b10
  } op_kind_e;

  typedef struct packed {
    logic     reg_write;
    logic     dst_is_rd;
    logic     b_is_imm;
    logic     branch;
    logic     mem_write;
    logic     wb_from_mem;
    logic     jump;
    op_kind_e op_kind;
  } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_ctl_e   alu_ctl
);

  logic known_op;

  // Main decode: opcode to selects and enables
  always_comb begin
    ctrl         = '0;
    ctrl.op_kind = OPK_ADD;
    known_op     = 1'b1;
    case (opcode)
      OPC_REG: begin
        ctrl.reg_write = 1'b1;
        ctrl.dst_is_rd = 1'b1;
        ctrl.op_kind   = OPK_FUNCT;
      end
      OPC_LOAD: begin
        ctrl.reg_write   = 1'b1;
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
      end
      OPC_STOR: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OPC_BREQ: begin
        ctrl.branch  = 1'b1;
        ctrl.op_kind = OPK_SUB;
      end
      OPC_ADDI: begin
        ctrl.reg_write = 1'b1;
        ctrl.b_is_imm  = 1'b1;
      end
      OPC_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: known_op = 1'b0;
    endcase
  end

  // ALU decode: operation class, then funct when deferred
  always_comb begin
    case (ctrl.op_kind)
      OPK_ADD: alu_ctl = ALU_ADD;
      OPK_SUB: alu_ctl = ALU_SUB;
      OPK_FUNCT: begin
        case (funct)
          FN_ADD:  alu_ctl = ALU_ADD;
          FN_SUB:  alu_ctl = ALU_SUB;
          FN_AND:  alu_ctl = ALU_AND;
          FN_OR:   alu_ctl = ALU_OR;
          FN_SLT:  alu_ctl = ALU_SLT;
          default: alu_ctl = ALU_ADD;
        endcase
      end
      default: alu_ctl = ALU_ADD;
    endcase
  end

  // Stores never write the register file
  always_comb begin
    if (opcode == OPC_STOR) begin
      assert_store_no_regwr_R5: assert (!ctrl.reg_write && ctrl.mem_write);
    end
  end

  // Unlisted opcodes leave every enable and PC redirect low
  always_comb begin
    if (!known_op) begin
      assert_unlisted_nop_R9: assert (!ctrl.reg_write && !ctrl.mem_write &&
                                      !ctrl.branch && !ctrl.jump);
    end
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_ctl_e     ctl,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] diff;
  logic         lt_signed;

  always_comb begin
    diff      = a - b;
    lt_signed = ($signed(a) < $signed(b));
    case (ctl)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, lt_signed};
      default: y = a + b;
    endcase
    zero = (y == '0);
  end

  // Set-less-than yields only 0 or 1
  always_comb begin
    if (ctl == ALU_SLT) begin
      assert_slt_boolean_R3: assert (y[W-1:1] == '0);
    end
  end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] ra3,
  output logic [W-1:0]  rd3
);

  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we) begin
      regs[wa] <= wd;
    end
  end

  always_comb begin
    rd1 = (ra1 == '0) ? '0 : regs[ra1];
    rd2 = (ra2 == '0) ? '0 : regs[ra2];
    rd3 = (ra3 == '0) ? '0 : regs[ra3];
  end

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 64,
  localparam int unsigned MAW      = $clog2(MEM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             ld_we,
  input  logic             ld_dmem,
  input  logic [MAW-1:0]   ld_addr,
  input  logic [31:0]      ld_data,
  input  logic [4:0]       dbg_reg_addr,
  output logic [31:0]      dbg_reg_data,
  input  logic [MAW-1:0]   dbg_mem_addr,
  output logic [31:0]      dbg_mem_data,
  output logic [31:0]      pc
);

  localparam int unsigned PCW = XLEN - 2;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // Program counter held as a word index
  logic [PCW-1:0] pc_q, pc_d, pcw_plus1, br_w, jmp_w;

  // Memories
  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];

  // Datapath signals
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y;
  logic [XLEN-1:0] load_word, wb_data;
  logic [RAW-1:0]  f_rs, f_rt, f_rd, wr_addr;
  logic [15:0]     f_imm;
  logic [25:0]     f_tgt;
  logic            instr_hit, d_hit, zero, take_br, core_step;
  logic            reg_we, st_we;
  logic [MAW-1:0]  d_idx;
  ctrl_t           ctrl;
  alu_ctl_e        alu_ctl;

  assign core_step = run_en && rst_q;

  // Fetch; a PC past the array fetches an all-zero word
  always_comb begin
    instr_hit = (pc_q[PCW-1:MAW] == '0);
    instr     = instr_hit ? imem[pc_q[MAW-1:0]] : '0;
    f_rs      = instr[25:21];
    f_rt      = instr[20:16];
    f_rd      = instr[15:11];
    f_imm     = instr[15:0];
    f_tgt     = instr[25:0];
    imm_ext   = {{(XLEN-16){f_imm[15]}}, f_imm};
  end

  sc_decoder u_dec (
    .opcode  (instr[31:26]),
    .funct   (instr[5:0]),
    .ctrl    (ctrl),
    .alu_ctl (alu_ctl)
  );

  sc_regfile #(
    .NREGS (32),
    .W     (XLEN)
  ) u_rf (
    .clk (clk),
    .we  (reg_we),
    .wa  (wr_addr),
    .wd  (wb_data),
    .ra1 (f_rs),
    .rd1 (rs_val),
    .ra2 (f_rt),
    .rd2 (rt_val),
    .ra3 (dbg_reg_addr),
    .rd3 (dbg_reg_data)
  );

  assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

  sc_alu #(
    .W (XLEN)
  ) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .ctl  (alu_ctl),
    .y    (alu_y),
    .zero (zero)
  );

  // Data access: aligned and inside the array, else inert
  always_comb begin
    d_hit     = (alu_y[XLEN-1:MAW+2] == '0) && (alu_y[1:0] == 2'b00);
    d_idx     = alu_y[MAW+1:2];
    load_word = d_hit ? dmem[d_idx] : '0;
    st_we     = core_step && ctrl.mem_write && d_hit;
  end

  // Write-back
  always_comb begin
    wr_addr = ctrl.dst_is_rd ? f_rd : f_rt;
    wb_data = ctrl.wb_from_mem ? load_word : alu_y;
    reg_we  = core_step && ctrl.reg_write;
  end

  // Instruction array: written only through the load port
  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) begin
      imem[ld_addr] <= ld_data;
    end
  end

  // Data array: load port has priority over stores
  always_ff @(posedge clk) begin
    if (ld_we && ld_dmem) begin
      dmem[ld_addr] <= ld_data;
    end else if (st_we) begin
      dmem[d_idx] <= rt_val;
    end
  end

  assign dbg_mem_data = dmem[dbg_mem_addr];

  // Next-PC selection
  always_comb begin
    pcw_plus1 = pc_q + 1'b1;
    br_w      = pcw_plus1 + imm_ext[PCW-1:0];
    jmp_w     = {pcw_plus1[PCW-1:26], f_tgt};
    take_br   = ctrl.branch && zero;
    if (ctrl.jump)    pc_d = jmp_w;
    else if (take_br) pc_d = br_w;
    else              pc_d = pcw_plus1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      pc_q <= '0;
    else if (run_en) pc_q <= pc_d;
  end

  assign pc = {pc_q, 2'b00};

  // PC sequencing checks
  assert_pc_step_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (run_en && !ctrl.jump && !take_br) |=> (pc_q == $past(pc_q) + 1'b1));

  assert_pc_hold_R1: assert property (@(posedge clk) disable iff (!rst_q)
    !run_en |=> $stable(pc_q));

  assert_branch_target_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (run_en && take_br && !ctrl.jump) |=>
      (pc_q == $past(pc_q) + 1'b1 + $past(imm_ext[PCW-1:0])));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (run_en && ctrl.jump) |=>
      (pc_q == {$past(pcw_plus1[PCW-1:26]), $past(instr[25:0])}));

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 64;
  localparam int MAW        = $clog2(MEM_WORDS);
  localparam int PROG_LEN   = 28;
  localparam int RUN_CYCLES = 40;

  // Expected register contents: {requirement number, register, value}
  localparam int NVEC = 14;
  localparam logic [40:0] REG_VECTORS [NVEC] = '{
    {4'd2,  5'd0,  32'h0000_0000},  // R2: write to register 0 discarded
    {4'd6,  5'd1,  32'h0000_0006},  // R6 R8 R9: skipped and no-op leave r1
    {4'd7,  5'd2,  32'hFFFF_FFFD},  // R7: negative immediate
    {4'd3,  5'd3,  32'h0000_0003},  // R3: add
    {4'd3,  5'd4,  32'h0000_0009},  // R3: sub
    {4'd3,  5'd5,  32'h0000_0004},  // R3: and
    {4'd3,  5'd6,  32'hFFFF_FFFF},  // R3: or
    {4'd3,  5'd7,  32'h0000_0001},  // R3: slt signed true
    {4'd3,  5'd8,  32'h0000_0000},  // R3: slt signed false
    {4'd4,  5'd9,  32'h0000_0006},  // R4: load of stored word
    {4'd4,  5'd10, 32'h1234_5678},  // R4: load of preloaded word
    {4'd7,  5'd12, 32'h0000_0010},  // R7: addi base
    {4'd6,  5'd13, 32'h0000_0000},  // R6: backward loop ran twice
    {4'd4,  5'd15, 32'h0000_0000}   // R4: out-of-range load gives zero
  };

  logic           clk;
  logic           rst_n;
  logic           run_en;
  logic           ld_we;
  logic           ld_dmem;
  logic [MAW-1:0] ld_addr;
  logic [31:0]    ld_data;
  logic [4:0]     dbg_reg_addr;
  logic [31:0]    dbg_reg_data;
  logic [MAW-1:0] dbg_mem_addr;
  logic [31:0]    dbg_mem_data;
  logic [31:0]    pc;

  int n_checks;
  int n_fails;
  bit done;

  logic [31:0] prog [PROG_LEN];

  sc_core #(
    .MEM_WORDS (MEM_WORDS)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .ld_we        (ld_we),
    .ld_dmem      (ld_dmem),
    .ld_addr      (ld_addr),
    .ld_data      (ld_data),
    .dbg_reg_addr (dbg_reg_addr),
    .dbg_reg_data (dbg_reg_data),
    .dbg_mem_addr (dbg_mem_addr),
    .dbg_mem_data (dbg_mem_data),
    .pc           (pc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'b000010, tgt};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic load_word(input logic to_dmem, input int idx, input logic [31:0] val);
    @(negedge clk);
    ld_we   = 1'b1;
    ld_dmem = to_dmem;
    ld_addr = MAW'(idx);
    ld_data = val;
    @(negedge clk);
    ld_we   = 1'b0;
  endtask

  task automatic read_reg(input int idx, output logic [31:0] val);
    dbg_reg_addr = 5'(idx);
    #1;
    val = dbg_reg_data;
  endtask

  task automatic read_mem(input int idx, output logic [31:0] val);
    dbg_mem_addr = MAW'(idx);
    #1;
    val = dbg_mem_data;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    run_en   = 1'b0;
    ld_we    = 1'b0;
    ld_dmem  = 1'b0;
    ld_addr  = '0;
    ld_data  = '0;
    dbg_reg_addr = '0;
    dbg_mem_addr = '0;

    prog[0]  = enc_i(6'b001000, 5'd0,  5'd1,  16'd6);
    prog[1]  = enc_i(6'b001000, 5'd0,  5'd2,  16'hFFFD);
    prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);
    prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);
    prog[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'b100100);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd6, 6'b100101);
    prog[6]  = enc_r(5'd2, 5'd1, 5'd7, 6'b101010);
    prog[7]  = enc_r(5'd1, 5'd2, 5'd8, 6'b101010);
    prog[8]  = enc_i(6'b101011, 5'd0,  5'd1,  16'd8);
    prog[9]  = enc_i(6'b100011, 5'd0,  5'd9,  16'd8);
    prog[10] = enc_i(6'b100011, 5'd0,  5'd10, 16'd4);
    prog[11] = enc_i(6'b001000, 5'd0,  5'd0,  16'd7);
    prog[12] = enc_i(6'b000100, 5'd1,  5'd2,  16'd1);
    prog[13] = enc_i(6'b000100, 5'd1,  5'd1,  16'd1);
    prog[14] = enc_i(6'b001000, 5'd0,  5'd1,  16'd99);
    prog[15] = enc_j(26'd17);
    prog[16] = enc_i(6'b001000, 5'd0,  5'd1,  16'd77);
    prog[17] = 32'hFC21_FFFF;
    prog[18] = enc_i(6'b001000, 5'd0,  5'd12, 16'd16);
    prog[19] = enc_i(6'b101011, 5'd12, 5'd4,  16'hFFFC);
    prog[20] = enc_i(6'b001000, 5'd0,  5'd13, 16'd2);
    prog[21] = enc_i(6'b001000, 5'd13, 5'd13, 16'hFFFF);
    prog[22] = enc_i(6'b000100, 5'd13, 5'd0,  16'd1);
    prog[23] = enc_i(6'b000100, 5'd0,  5'd0,  16'hFFFD);
    prog[24] = enc_i(6'b001000, 5'd0,  5'd15, 16'hFFFF);
    prog[25] = enc_i(6'b101011, 5'd0,  5'd1,  16'd1);
    prog[26] = enc_i(6'b100011, 5'd0,  5'd15, 16'd256);
    prog[27] = enc_j(26'd27);

    // R1: PC is zero during reset
    repeat (2) @(negedge clk);
    check("R1", "pc in reset", pc, 32'h0);

    // R10: preload while idle
    for (int i = 0; i < PROG_LEN; i++) load_word(1'b0, i, prog[i]);
    load_word(1'b1, 0, 32'hAAAA_5555);
    load_word(1'b1, 1, 32'h1234_5678);
    read_mem(1, v);
    check("R10", "dmem[1] after load", v, 32'h1234_5678);

    // R1: release reset, PC holds with run_en low
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1", "pc holds while idle", pc, 32'h0);

    // R1 R7: one enabled clock
    run_en = 1'b1;
    @(negedge clk);
    run_en = 1'b0;
    check("R1", "pc after one step", pc, 32'h4);
    read_reg(1, v);
    check("R7", "r1 after first addi", v, 32'h6);

    // Run the rest of the program
    @(negedge clk);
    run_en = 1'b1;
    repeat (RUN_CYCLES) @(negedge clk);
    run_en = 1'b0;

    // R8: halted on self jump at byte 108
    check("R8", "pc at halt loop", pc, 32'd108);

    // Register table walk
    for (int k = 0; k < NVEC; k++) begin
      read_reg(int'(REG_VECTORS[k][36:32]), v);
      if (v !== REG_VECTORS[k][31:0]) begin
        n_checks++;
        n_fails++;
        $display("FAIL R%0d register %0d: actual=%08h expected=%08h",
                 REG_VECTORS[k][40:37], REG_VECTORS[k][36:32], v, REG_VECTORS[k][31:0]);
      end else begin
        n_checks++;
      end
    end

    // R5: stores, including negative offset and a dropped misaligned one
    read_mem(2, v);
    check("R5", "dmem[2] stored", v, 32'h6);
    read_mem(3, v);
    check("R5", "dmem[3] stored via negative offset", v, 32'h9);
    read_mem(0, v);
    check("R5", "dmem[0] untouched by misaligned store", v, 32'hAAAA_5555);
    read_mem(1, v);
    check("R4", "dmem[1] unchanged by loads", v, 32'h1234_5678);

    // R8: self jump keeps PC fixed while running
    @(negedge clk);
    run_en = 1'b1;
    repeat (3) @(negedge clk);
    run_en = 1'b0;
    check("R8", "pc stays on self jump", pc, 32'd108);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    run_en = 1'b1;
    rst_n  = 1'b0;
    #1;
    check("R1", "pc on async reset", pc, 32'h0);
    run_en = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule